// File: doc/BRIEF.md
# Reverse Page-Table Searcher

This block answers the inverse of a page-table walk. It is given the base of a five-level page table and a physical address. It then visits every reachable entry of the tree in depth-first order until it finds a leaf that maps the physical page. The virtual address of that leaf is rebuilt from the chain of table indices the search followed, and the byte offset of the requested physical address is placed in the low bits.

A search starts with a one-cycle request that carries the table root and the target. All table reads go out one at a time over a 64-bit read port. The port has a valid/ready request side and a response that returns one cycle or more after the request is accepted. When the search ends, a one-cycle done pulse is raised together with the result. The result is the found virtual address, or zero if no leaf maps the page. Zero is never a legal virtual address, so zero alone marks a miss.

Top module: `revmap_dfs_search`

## Requirements
- R1: A start pulse seen while idle captures the root base and target, and the first read goes to the root base. An empty top table (all four entries invalid) costs exactly four reads.
- R2: Tables are walked with these entry counts, from top to leaf: 4, 512, 512, 256, 512. The entry strides are 8, 8, 8, 16 and 8 bytes. For a 16-byte entry, the pointer is read from its low 8 bytes. Every read address is a multiple of 8. The first and last index of every level can be reached.
- R3: Entry bits [2:1] hold the aperture code, and the value 0 means invalid. Bits [31:8] hold the 24-bit page field, and a child or page address is this field shifted left by 12. The search never descends through an invalid entry, and it never reports an invalid leaf as a match.
- R4: The search descends into each valid directory entry before it reads that entry's next sibling. When a table is used up, the search returns to the parent table and goes on with the sibling after the entry it descended through. A top entry that points to an empty next-level table costs 4 + 512 reads.
- R5: A read request keeps its valid and address steady until ready is seen. No new request is issued while a response is still pending.
- R6: A valid leaf matches when its page field equals target bits [35:12]. The result is then built from five parts: the top index at bit 47, the second at 38, the third at 29, the fourth at 21, the leaf index at 12, and target bits [11:0] below them. The first match in search order is the one reported.
- R7: When the whole tree has been searched with no match, the result is zero.
- R8: `done` is high for one cycle per search, and `result_va` changes only with it. Reset clears `done`, `mem_req_valid` and `result_va`.
- R9: A start pulse during a running search is ignored. It neither changes the result nor produces a second done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_valid | input | 1 | Start a search (taken only while idle) |
| start_root | input | 36 | Physical base of the top-level table |
| start_target | input | 36 | Physical address to look up |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 36 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| done | output | 1 | One-cycle end-of-search pulse |
| result_va | output | 49 | Reconstructed virtual address, or zero |

## Verification
Some properties are checked on every cycle:
- Requests hold steady while stalled.
- Only one read is outstanding at a time.
- Read addresses are 8-byte aligned.
- `done` is a single-cycle pulse.
- The result only moves together with `done`.

Other behaviour depends on table contents, so only the bench's scenarios can show it:
- Depth-first order, with first-match priority.
- The 16-byte stride at the fourth level.
- The last-index boundaries at every level.
- Skipping invalid directories and leaves.
- The exact read counts that expose wrong loop bounds.
- Ignoring a start during a search.

// File: rtl/revmap_pkg.sv
package revmap_pkg;

   localparam int unsigned NLVL  = 5;
   localparam int unsigned IDX_W = 9;
   localparam int unsigned LVL_W = $clog2(NLVL);

   // index width taken from the virtual address at each level (top first)
   function automatic int unsigned lvl_bits(input int unsigned l);
      case (l)
         0:       return 2;
         3:       return 8;
         default: return 9;
      endcase
   endfunction

   // lowest virtual-address bit set by each level's index
   function automatic int unsigned lvl_lsb(input int unsigned l);
      case (l)
         0:       return 47;
         1:       return 38;
         2:       return 29;
         3:       return 21;
         default: return 12;
      endcase
   endfunction

   // log2 of the entry stride in bytes
   function automatic int unsigned ent_shift(input int unsigned l);
      return (l == 3) ? 4 : 3;
   endfunction

   typedef enum logic [1:0] {
      S_IDLE,
      S_ISSUE,
      S_WAIT,
      S_NEXT
   } srch_state_t;

endpackage

// File: rtl/revmap_entry_decode.sv
module revmap_entry_decode #(
   parameter int unsigned ENTRY_W      = 64,
   parameter int unsigned ADDR_LSB     = 8,
   parameter int unsigned ADDR_FIELD_W = 24,
   parameter int unsigned PAGE_SHIFT   = 12,
   localparam int unsigned PA_W        = ADDR_FIELD_W + PAGE_SHIFT
) (
   input  logic [ENTRY_W-1:0] entry,
   output logic               valid,
   output logic [PA_W-1:0]    ptr
);

   logic unused_bits;

   assign valid = |entry[2:1];
   assign ptr   = {entry[ADDR_LSB+ADDR_FIELD_W-1 -: ADDR_FIELD_W], {PAGE_SHIFT{1'b0}}};

   generate
      if (ADDR_LSB + ADDR_FIELD_W < ENTRY_W) begin : g_hi
         assign unused_bits = ^{entry[ENTRY_W-1:ADDR_LSB+ADDR_FIELD_W], entry[ADDR_LSB-1:3], entry[0]};
      end else begin : g_nohi
         assign unused_bits = ^{entry[ADDR_LSB-1:3], entry[0]};
      end
   endgenerate

endmodule

// File: rtl/revmap_index_stack.sv
module revmap_index_stack #(
   parameter int unsigned NLVL  = 5,
   parameter int unsigned IDX_W = 9,
   parameter int unsigned PA_W  = 36,
   localparam int unsigned LVL_W = $clog2(NLVL)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    op_init,
   input  logic                    op_push,
   input  logic                    op_pop,
   input  logic                    op_incr,
   input  logic [PA_W-1:0]         root_base,
   input  logic [PA_W-1:0]         child_base,
   output logic                    at_root,
   output logic                    at_leaf,
   output logic                    cur_last,
   output logic [PA_W-1:0]         cur_addr,
   output logic [NLVL*IDX_W-1:0]   idx_flat
);

   logic [LVL_W-1:0] lvl_q;
   logic [PA_W-1:0]  addr_l [NLVL];
   logic             last_l [NLVL];

   always_ff @(posedge clk) begin
      if (!rst_n)        lvl_q <= '0;
      else if (op_init)  lvl_q <= '0;
      else if (op_push)  lvl_q <= lvl_q + 1'b1;
      else if (op_pop)   lvl_q <= lvl_q - 1'b1;
   end

   generate
      for (genvar l = 0; l < NLVL; l++) begin : g_lvl
         localparam int unsigned BITS  = revmap_pkg::lvl_bits(l);
         localparam int unsigned SHIFT = revmap_pkg::ent_shift(l);
         localparam int unsigned LAST  = (1 << BITS) - 1;
         logic [IDX_W-1:0] idx_q;
         logic [PA_W-1:0]  base_q;

         if (l == 0) begin : g_root
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  idx_q  <= '0;
                  base_q <= '0;
               end else if (op_init) begin
                  idx_q  <= '0;
                  base_q <= root_base;
               end else if (op_incr && lvl_q == '0) begin
                  idx_q  <= idx_q + 1'b1;
               end
            end
         end else begin : g_inner
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  idx_q  <= '0;
                  base_q <= '0;
               end else if (op_init) begin
                  idx_q  <= '0;
               end else if (op_push && int'(lvl_q) + 1 == l) begin
                  idx_q  <= '0;
                  base_q <= child_base;
               end else if (op_incr && int'(lvl_q) == l) begin
                  idx_q  <= idx_q + 1'b1;
               end
            end
         end

         assign addr_l[l] = base_q + (PA_W'(idx_q) << SHIFT);
         assign last_l[l] = (idx_q == IDX_W'(LAST));
         assign idx_flat[l*IDX_W +: IDX_W] = idx_q;
      end
   endgenerate

   always_comb begin
      cur_addr = '0;
      cur_last = 1'b0;
      for (int i = 0; i < NLVL; i++) begin
         if (int'(lvl_q) == i) begin
            cur_addr = addr_l[i];
            cur_last = last_l[i];
         end
      end
   end

   assign at_root = (lvl_q == '0);
   assign at_leaf = (lvl_q == LVL_W'(NLVL - 1));

endmodule

// File: rtl/revmap_va_build.sv
module revmap_va_build #(
   parameter int unsigned NLVL       = 5,
   parameter int unsigned IDX_W      = 9,
   parameter int unsigned VA_W       = 49,
   parameter int unsigned PAGE_SHIFT = 12
) (
   input  logic [NLVL*IDX_W-1:0] idx_flat,
   input  logic [PAGE_SHIFT-1:0] page_off,
   output logic [VA_W-1:0]       va
);

   logic [VA_W-1:0] part [NLVL+1];

   assign part[0] = VA_W'(page_off);

   generate
      for (genvar l = 0; l < NLVL; l++) begin : g_lvl
         localparam int unsigned BITS = revmap_pkg::lvl_bits(l);
         localparam int unsigned LSB  = revmap_pkg::lvl_lsb(l);
         assign part[l+1] = part[l] | (VA_W'(idx_flat[l*IDX_W +: BITS]) << LSB);
         if (BITS < IDX_W) begin : g_spare
            logic unused_hi;
            assign unused_hi = ^idx_flat[l*IDX_W+BITS +: IDX_W-BITS];
         end
      end
   endgenerate

   assign va = part[NLVL];

endmodule

// File: rtl/revmap_dfs_search.sv
module revmap_dfs_search #(
   parameter int unsigned ENTRY_W      = 64,
   parameter int unsigned ADDR_FIELD_W = 24,
   parameter int unsigned ADDR_LSB     = 8,
   parameter int unsigned PAGE_SHIFT   = 12,
   parameter int unsigned VA_W         = 49,
   localparam int unsigned PA_W        = ADDR_FIELD_W + PAGE_SHIFT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_valid,
   input  logic [PA_W-1:0]     start_root,
   input  logic [PA_W-1:0]     start_target,
   output logic                mem_req_valid,
   input  logic                mem_req_ready,
   output logic [PA_W-1:0]     mem_req_addr,
   input  logic                mem_rsp_valid,
   input  logic [ENTRY_W-1:0]  mem_rsp_data,
   output logic                done,
   output logic [VA_W-1:0]     result_va
);
   import revmap_pkg::*;

   if (VA_W != lvl_lsb(0) + lvl_bits(0)) begin : g_bad_va
      $error("VA_W does not match the level geometry");
   end
   if (ADDR_LSB + ADDR_FIELD_W > ENTRY_W || ADDR_LSB < 3) begin : g_bad_field
      $error("page field does not fit the entry");
   end

   srch_state_t               state_q, state_d;
   logic [PA_W-1:0]           target_q;
   logic                      done_q;
   logic [VA_W-1:0]           va_q;
   logic                      op_init, op_push, op_pop, op_incr;
   logic                      finish, hit;
   logic                      ent_valid;
   logic [PA_W-1:0]           ent_ptr;
   logic                      at_root, at_leaf, cur_last;
   logic [PA_W-1:0]           cur_addr;
   logic [NLVL*IDX_W-1:0]     idx_flat;
   logic [VA_W-1:0]           va_built;

   revmap_entry_decode #(
      .ENTRY_W(ENTRY_W), .ADDR_LSB(ADDR_LSB),
      .ADDR_FIELD_W(ADDR_FIELD_W), .PAGE_SHIFT(PAGE_SHIFT)
   ) dec_i (
      .entry(mem_rsp_data), .valid(ent_valid), .ptr(ent_ptr)
   );

   revmap_index_stack #(
      .NLVL(NLVL), .IDX_W(IDX_W), .PA_W(PA_W)
   ) stk_i (
      .clk(clk), .rst_n(rst_n),
      .op_init(op_init), .op_push(op_push), .op_pop(op_pop), .op_incr(op_incr),
      .root_base(start_root), .child_base(ent_ptr),
      .at_root(at_root), .at_leaf(at_leaf), .cur_last(cur_last),
      .cur_addr(cur_addr), .idx_flat(idx_flat)
   );

   revmap_va_build #(
      .NLVL(NLVL), .IDX_W(IDX_W), .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT)
   ) vab_i (
      .idx_flat(idx_flat), .page_off(target_q[PAGE_SHIFT-1:0]), .va(va_built)
   );

   always_comb begin
      state_d = state_q;
      op_init = 1'b0;
      op_push = 1'b0;
      op_pop  = 1'b0;
      op_incr = 1'b0;
      finish  = 1'b0;
      hit     = 1'b0;
      case (state_q)
         S_IDLE: begin
            if (start_valid) begin
               op_init = 1'b1;
               state_d = S_ISSUE;
            end
         end
         S_ISSUE: begin
            if (mem_req_ready) state_d = S_WAIT;
         end
         S_WAIT: begin
            if (mem_rsp_valid) begin
               if (!ent_valid) begin
                  state_d = S_NEXT;
               end else if (!at_leaf) begin
                  op_push = 1'b1;
                  state_d = S_ISSUE;
               end else if (ent_ptr[PA_W-1:PAGE_SHIFT] == target_q[PA_W-1:PAGE_SHIFT]) begin
                  hit     = 1'b1;
                  finish  = 1'b1;
                  state_d = S_IDLE;
               end else begin
                  state_d = S_NEXT;
               end
            end
         end
         S_NEXT: begin
            if (!cur_last) begin
               op_incr = 1'b1;
               state_d = S_ISSUE;
            end else if (at_root) begin
               finish  = 1'b1;
               state_d = S_IDLE;
            end else begin
               op_pop  = 1'b1;
            end
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         target_q <= '0;
         done_q   <= 1'b0;
         va_q     <= '0;
      end else begin
         state_q <= state_d;
         done_q  <= finish;
         if (op_init) target_q <= start_target;
         if (finish)  va_q     <= hit ? va_built : '0;
      end
   end

   assign mem_req_valid = (state_q == S_ISSUE);
   assign mem_req_addr  = cur_addr;
   assign done          = done_q;
   assign result_va     = va_q;

endmodule

// File: rtl/revmap_dfs_search_chk.sv
module revmap_dfs_search_chk #(
   parameter int unsigned PA_W = 36,
   parameter int unsigned VA_W = 49
) (
   input logic            clk,
   input logic            rst_n,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic [PA_W-1:0] mem_req_addr,
   input logic            mem_rsp_valid,
   input logic            done,
   input logic [VA_W-1:0] result_va
);

   logic pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                              pend_q <= 1'b0;
      else if (mem_req_valid && mem_req_ready) pend_q <= 1'b1;
      else if (mem_rsp_valid)                  pend_q <= 1'b0;
   end

   a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   a_r5_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_ready |-> !pend_q);

   a_r2_aligned_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> mem_req_addr[2:0] == 3'b000);

   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_result_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result_va) |-> done);

   a_r8_no_read_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !pend_q);

endmodule

bind revmap_dfs_search revmap_dfs_search_chk #(.PA_W(PA_W), .VA_W(VA_W)) chk_i (
   .clk(clk), .rst_n(rst_n),
   .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
   .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
   .done(done), .result_va(result_va)
);

// File: tb/revmap_dfs_search_tb_top.sv
`timescale 1ns/1ps
module revmap_dfs_search_tb_top;
   localparam int PA_W = 36;
   localparam int VA_W = 49;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_valid = 1'b0;
   logic [PA_W-1:0] start_root = '0;
   logic [PA_W-1:0] start_target = '0;
   logic            mem_req_valid;
   logic            mem_req_ready = 1'b0;
   logic [PA_W-1:0] mem_req_addr;
   logic            mem_rsp_valid = 1'b0;
   logic [63:0]     mem_rsp_data = '0;
   logic            done;
   logic [VA_W-1:0] result_va;

   always #10 clk = ~clk;

   revmap_dfs_search dut_i (
      .clk(clk), .rst_n(rst_n),
      .start_valid(start_valid), .start_root(start_root), .start_target(start_target),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done(done), .result_va(result_va)
   );

   // ---------------- memory model ----------------
   logic [63:0] mem [logic [PA_W-1:0]];
   int unsigned cyc = 0, n_reads = 0, n_viol = 0;
   logic        pend = 1'b0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      mem_req_ready <= (cyc % 5) != 2;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
         if (pend) n_viol <= n_viol + 1;
         n_reads       <= n_reads + 1;
         mem_rsp_valid <= 1'b1;
         mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
         pend          <= 1'b1;
      end else if (mem_rsp_valid) begin
         pend <= 1'b0;
      end
   end

   // ---------------- scoreboard ----------------
   logic [VA_W-1:0] exp_q[$];
   string           tag_q[$];
   int tests = 0, fails = 0;
   int mon_tests = 0, mon_fails = 0;
   int unsigned n_done = 0;

   always @(negedge clk) begin
      if (rst_n && done) begin
         logic [VA_W-1:0] e;
         string t;
         n_done++;
         mon_tests++;
         if (exp_q.size() == 0) begin
            mon_fails++;
            $display("FAIL R9 unexpected done: actual %h expected no result", result_va);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (result_va !== e) begin
               mon_fails++;
               $display("FAIL %s result: actual %h expected %h", t, result_va, e);
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint unsigned act, input longint unsigned exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] ent(input logic [PA_W-1:0] a, input bit v);
      return {32'h0, a[35:12], 5'b0, (v ? 2'b01 : 2'b00), 1'b0};
   endfunction

   function automatic logic [PA_W-1:0] tbl(input int n);
      return PA_W'(36'h10_0000) + PA_W'(n * 4096);
   endfunction

   function automatic logic [VA_W-1:0] expva(input int i0, i1, i2, i3, i4, input logic [11:0] off);
      return (VA_W'(i0) << 47) | (VA_W'(i1) << 38) | (VA_W'(i2) << 29) |
             (VA_W'(i3) << 21) | (VA_W'(i4) << 12) | VA_W'(off);
   endfunction

   task automatic path(input logic [PA_W-1:0] t0, t1, t2, t3, t4,
                       input int i0, i1, i2, i3, i4,
                       input logic [PA_W-1:0] page, input bit leaf_v);
      mem[t0 + PA_W'(8 * i0)]  = ent(t1, 1'b1);
      mem[t1 + PA_W'(8 * i1)]  = ent(t2, 1'b1);
      mem[t2 + PA_W'(8 * i2)]  = ent(t3, 1'b1);
      mem[t3 + PA_W'(16 * i3)] = ent(t4, 1'b1);
      mem[t4 + PA_W'(8 * i4)]  = ent(page, leaf_v);
   endtask

   task automatic run(input logic [PA_W-1:0] root, input logic [PA_W-1:0] tgt,
                      input logic [VA_W-1:0] exp, input string tag);
      int unsigned d0;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      d0 = n_done;
      @(negedge clk);
      start_valid = 1'b1;
      start_root = root;
      start_target = tgt;
      @(negedge clk);
      start_valid = 1'b0;
      while (n_done == d0) @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      if (cyc > 150000) begin
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("  [TB] %0d tests run, %0d failed", tests + mon_tests + 1, fails + mon_fails + 1);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   localparam logic [PA_W-1:0] P = 36'h0_0777_7000;
   localparam logic [PA_W-1:0] Q = 36'h0_0888_8000;

   initial begin
      logic [PA_W-1:0] root;
      int unsigned r0, d0;
      root = tbl(0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(done == 1'b0, "R8", "done after reset", done, 0);
      check(mem_req_valid == 1'b0, "R8", "req_valid after reset", mem_req_valid, 0);
      check(result_va == '0, "R8", "result after reset", result_va, 0);

      // R1 / R7: empty top table
      mem.delete();
      r0 = n_reads;
      run(root, 36'h0_1234_5000, '0, "R7");
      check(n_reads - r0 == 4, "R1", "reads on empty top table", n_reads - r0, 4);

      // R6: single mapping with offset
      mem.delete();
      path(root, tbl(1), tbl(2), tbl(3), tbl(4), 1, 5, 7, 3, 9, 36'h0_ABCD_E000, 1'b1);
      run(root, 36'h0_ABCD_E123, expva(1, 5, 7, 3, 9, 12'h123), "R6");
      repeat (10) @(negedge clk);
      check(result_va == expva(1, 5, 7, 3, 9, 12'h123), "R8", "result holds after done",
            result_va, expva(1, 5, 7, 3, 9, 12'h123));

      // R9: start during a search is ignored
      exp_q.push_back(expva(1, 5, 7, 3, 9, 12'h00F));
      tag_q.push_back("R9");
      d0 = n_done;
      @(negedge clk);
      start_valid = 1'b1;
      start_root = root;
      start_target = 36'h0_ABCD_E00F;
      @(negedge clk);
      start_valid = 1'b0;
      repeat (6) @(negedge clk);
      start_valid = 1'b1;
      start_root = tbl(40);
      start_target = 36'h0_0000_1000;
      @(negedge clk);
      start_valid = 1'b0;
      while (n_done == d0) @(negedge clk);
      repeat (40) @(negedge clk);
      check(n_done == d0 + 1, "R9", "done count", n_done - d0, 1);

      // R2: 16-byte stride at the fourth level
      mem.delete();
      path(root, tbl(1), tbl(2), tbl(3), tbl(4), 0, 0, 0, 200, 0, 36'h5_5555_5000, 1'b1);
      run(root, 36'h5_5555_5010, expva(0, 0, 0, 200, 0, 12'h010), "R2");

      // R2: last index at every level
      mem.delete();
      path(root, tbl(1), tbl(2), tbl(3), tbl(4), 3, 511, 511, 255, 511, 36'hF_FFFF_F000, 1'b1);
      run(root, 36'hF_FFFF_FFFF, expva(3, 511, 511, 255, 511, 12'hFFF), "R2");

      // R4 / R6: depth-first order, first match wins
      mem.delete();
      path(root, tbl(1), tbl(2), tbl(3), tbl(4), 1, 0, 0, 0, 0, Q, 1'b1);
      path(root, tbl(1), tbl(5), tbl(6), tbl(7), 1, 300, 0, 0, 0, P, 1'b1);
      path(root, tbl(8), tbl(9), tbl(10), tbl(11), 2, 0, 0, 0, 0, P, 1'b1);
      run(root, P | 36'h044, expva(1, 300, 0, 0, 0, 12'h044), "R4");

      // R3: invalid directory and invalid leaf are skipped
      mem.delete();
      path(root, tbl(1), tbl(2), tbl(3), tbl(4), 0, 1, 1, 1, 1, P, 1'b1);
      mem[root] = ent(tbl(1), 1'b0);
      path(root, tbl(5), tbl(6), tbl(7), tbl(8), 2, 4, 4, 4, 3, P, 1'b0);
      path(root, tbl(5), tbl(6), tbl(7), tbl(8), 2, 4, 4, 4, 4, P, 1'b1);
      run(root, P, expva(2, 4, 4, 4, 4, 12'h000), "R3");

      // R4 / R7: empty child table is exhausted then popped
      mem.delete();
      mem[root + 36'd8] = ent(tbl(1), 1'b1);
      r0 = n_reads;
      run(root, P, '0, "R7");
      check(n_reads - r0 == 516, "R4", "reads with one empty child table", n_reads - r0, 516);

      check(n_viol == 0, "R5", "requests while response pending", n_viol, 0);
      check(exp_q.size() == 0, "R8", "results left unmatched", exp_q.size(), 0);

      $display("  [TB] %0d tests run, %0d failed", tests + mon_tests, fails + mon_fails);
      $finish;
   end

endmodule